// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces a pulse-width-modulated waveform for a display backlight from a reference clock, which is also the block's clock. Two counters are nested. An 8-bit prescaler counter divides the reference clock into prescaled ticks. A 16-bit scale counter counts those ticks to set the period. A 16-bit level value sets the high time. A control register enables the waveform and inverts its polarity. Software reaches all settings through a byte-wide register port (address, write data, write strobe, combinational read data). A pin-control register holds a 2-bit mux field that hands one general-purpose pin to the waveform.

The sequencer has three states. IDLE holds both counters at zero while the enable bit is clear. COUNT advances the prescaler and the scale counter, and the output is active while the scale count is below the level. WRAP is the one-cycle counter reset that closes each period, and the output is inactive there.

The transitions are as follows. IDLE→COUNT happens on enable when the prescaler and scale are both non-zero. IDLE→WRAP happens on enable when either of them is zero. COUNT→WRAP happens when the last prescaled tick of the last scale step ends, or when a setting has been written to zero. WRAP→COUNT happens when both settings are non-zero. WRAP→WRAP repeats while either setting is zero. Any state returns to IDLE while the enable bit is clear. Writes are applied at once and are not staged as a group, so a period that is in progress uses the new values.

Top module: `bl_pwm_top`

## Requirements
- R1: With prescaler P and scale S both non-zero and the block enabled, each period lasts P×S+1 reference cycles. The final cycle of the period is the reset cycle, and the output is inactive in it.
- R2: Every period starts with its active phase. For a level L below S, the output is active for P×L cycles and then inactive for P×(S−L)+1 cycles.
- R3: When L is greater than or equal to S, the output is active for all P×S counting cycles and inactive only during the reset cycle.
- R4: When L is zero, the output never becomes active while the block is enabled.
- R5: The registers are addressed relative to BASE_ADDR (default 0x40). Offset +0 holds the prescaler. Offsets +1 and +2 hold the scale, low byte first. Offsets +3 and +4 hold the level, low byte first. Offset +5 is control: bit 1 enables and bit 0 inverts, and bits 7:2 read as zero. Offset +6 is pin control. Reads return the stored values, and unmapped addresses read zero.
- R6: When the block is enabled with P or S equal to zero, every period lasts one reference cycle and the output stays at its inactive level.
- R7: While the enable bit is clear, the output sits at its inactive level: 0, or 1 when inverted. When enable is set again, the output becomes active (for L>0) two clock edges after the write edge.
- R8: With the invert bit set, pwm_o is the complement of the non-inverted waveform. The measured run lengths then swap between the high and low levels.
- R9: After reset, the pin is not driven (pin_oe=0). Writing the mux field (pin-control bits 7:6, the fourth pin's field) with code 2'b10 drives the pin with the waveform from the next cycle. Any other code releases the pin, and pin_out then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe; the write happens on the rising clock edge |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_o | output | 1 | Waveform after the polarity bit is applied |
| pin_oe | output | 1 | Pin output enable, high when the mux selects the waveform |
| pin_out | output | 1 | Pin data, which follows pwm_o while the pin is driven |

## Verification
The bench measures whole active and inactive runs over several combinations of prescaler, scale and level, including a level above the scale. An off-by-one in the reset cycle would show up as a low run one cycle too long or too short. A wrong comparison against the level would shorten or lengthen the high run by one prescaled tick. Zero settings and a zero level are held for a window to catch a design that divides by zero into a runaway count or emits a one-cycle glitch. Re-enable timing and inverted idle levels are checked against exact cycles, and the pin is checked both released and driven, to catch a mux that drives out of reset.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } pwm_state_e;

    localparam logic [1:0] MUX_PWM = 2'b10;
    localparam int         BYTE_W  = 8;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter int              SCL_W     = 16,
    parameter int              NUM_PINS  = 4,
    parameter int              PIN_IDX   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    input  logic                reg_we,
    output logic [BYTE_W-1:0]   reg_rdata,
    output logic [BYTE_W-1:0]   pre_o,
    output logic [SCL_W-1:0]    scl_o,
    output logic [SCL_W-1:0]    lvl_o,
    output logic                en_o,
    output logic                inv_o,
    output logic [1:0]          mux_o
);

    localparam int SB      = SCL_W / BYTE_W;
    localparam int PIN_W   = 2 * NUM_PINS;
    localparam int MUX_LSB = 2 * PIN_IDX;
    localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(1 + 2 * SB);
    localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(2 + 2 * SB);

    logic [ADDR_W-1:0] rel;
    logic [BYTE_W-1:0] pre_q;
    logic              en_q, inv_q;
    logic [PIN_W-1:0]  pin_q;
    logic [BYTE_W-1:0] scl_b [SB];
    logic [BYTE_W-1:0] lvl_b [SB];

    assign rel = reg_addr - BASE_ADDR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            en_q  <= 1'b0;
            inv_q <= 1'b0;
            pin_q <= '0;
        end else if (reg_we) begin
            if (rel == A_PRE) pre_q <= reg_wdata;
            if (rel == A_CTL) begin
                en_q  <= reg_wdata[1];
                inv_q <= reg_wdata[0];
            end
            if (rel == A_PIN) pin_q <= reg_wdata[PIN_W-1:0];
        end
    end

    for (genvar b = 0; b < SB; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] A_S = ADDR_W'(1 + b);
        localparam logic [ADDR_W-1:0] A_L = ADDR_W'(1 + SB + b);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_b[b] <= '0;
                lvl_b[b] <= '0;
            end else if (reg_we) begin
                if (rel == A_S) scl_b[b] <= reg_wdata;
                if (rel == A_L) lvl_b[b] <= reg_wdata;
            end
        end
        assign scl_o[BYTE_W*b +: BYTE_W] = scl_b[b];
        assign lvl_o[BYTE_W*b +: BYTE_W] = lvl_b[b];
    end

    always_comb begin
        reg_rdata = '0;
        if (rel == A_PRE) reg_rdata = pre_q;
        if (rel == A_CTL) reg_rdata = {6'b0, en_q, inv_q};
        if (rel == A_PIN) reg_rdata = BYTE_W'(pin_q);
        for (int b = 0; b < SB; b++) begin
            if (rel == ADDR_W'(1 + b))      reg_rdata = scl_b[b];
            if (rel == ADDR_W'(1 + SB + b)) reg_rdata = lvl_b[b];
        end
    end

    assign pre_o = pre_q;
    assign en_o  = en_q;
    assign inv_o = inv_q;
    assign mux_o = pin_q[MUX_LSB +: 2];

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rel == A_CTL) |-> (reg_rdata[7:2] == 6'b0)); // R5

    AST_CTRL_WRITE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && rel == A_CTL) |=> (en_o == $past(reg_wdata[1]))); // R5

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
#(
    parameter int SCL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [BYTE_W-1:0]  pre_div,
    input  logic [SCL_W-1:0]   scale,
    input  logic [SCL_W-1:0]   level,
    output logic               active_o,
    output pwm_state_e         state_o
);

    pwm_state_e        state_q, state_d;
    logic [BYTE_W-1:0] pc_q, pc_d;
    logic [SCL_W-1:0]  sc_q, sc_d;
    logic              params_ok, pc_last, sc_last;

    assign params_ok = (pre_div != '0) && (scale != '0);
    assign pc_last   = (pc_q >= pre_div - BYTE_W'(1));
    assign sc_last   = (sc_q >= scale - SCL_W'(1));

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        sc_d    = sc_q;
        if (!en) begin
            state_d = ST_IDLE;
            pc_d    = '0;
            sc_d    = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WRAP: begin
                    state_d = params_ok ? ST_COUNT : ST_WRAP;
                    pc_d    = '0;
                    sc_d    = '0;
                end
                ST_COUNT: begin
                    if (!params_ok) begin
                        state_d = ST_WRAP;
                        pc_d    = '0;
                        sc_d    = '0;
                    end else if (pc_last) begin
                        pc_d = '0;
                        if (sc_last) begin
                            state_d = ST_WRAP;
                            sc_d    = '0;
                        end else begin
                            sc_d = sc_q + SCL_W'(1);
                        end
                    end else begin
                        pc_d = pc_q + BYTE_W'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    pc_d    = '0;
                    sc_d    = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            sc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            sc_q    <= sc_d;
        end
    end

    always_comb begin
        active_o = (state_q == ST_COUNT) && (sc_q < level);
        state_o  = state_q;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE && pc_q == '0 && sc_q == '0)); // R7

    AST_ZERO_PARAM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (pre_div == '0 || scale == '0)) |=> (state_q == ST_WRAP)); // R6

    AST_WRAP_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && en && params_ok) |=> (state_q == ST_COUNT)); // R1

endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux
    import bl_pwm_pkg::*;
(
    input  logic [1:0] mux_sel,
    input  logic       pwm_i,
    output logic       pin_oe,
    output logic       pin_out
);

    always_comb begin
        pin_oe  = (mux_sel == MUX_PWM);
        pin_out = pin_oe & pwm_i;
    end

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h40,
    parameter int          SCL_W     = 16,
    parameter int          NUM_PINS  = 4,
    parameter int          PIN_IDX   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic              pwm_o,
    output logic              pin_oe,
    output logic              pin_out
);

    localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(BASE_ADDR) + ADDR_W'(2 + 2 * (SCL_W / BYTE_W));
    localparam int MUX_LSB = 2 * PIN_IDX;

    logic [BYTE_W-1:0] pre_w;
    logic [SCL_W-1:0]  scl_w, lvl_w;
    logic              en_w, inv_w, active_w;
    logic [1:0]        mux_w;
    pwm_state_e        state_w;

    bl_pwm_regs #(
        .ADDR_W(ADDR_W), .BASE_ADDR(ADDR_W'(BASE_ADDR)), .SCL_W(SCL_W),
        .NUM_PINS(NUM_PINS), .PIN_IDX(PIN_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pre_o(pre_w), .scl_o(scl_w),
        .lvl_o(lvl_w), .en_o(en_w), .inv_o(inv_w), .mux_o(mux_w)
    );

    bl_pwm_core #(.SCL_W(SCL_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_w), .pre_div(pre_w), .scale(scl_w),
        .level(lvl_w), .active_o(active_w), .state_o(state_w)
    );

    assign pwm_o = active_w ^ inv_w;

    bl_pwm_pinmux u_pinmux (
        .mux_sel(mux_w), .pwm_i(pwm_o), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    AST_WRAP_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_WRAP) |-> (pwm_o == inv_w)); // R1

    AST_MUX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PIN && reg_wdata[MUX_LSB +: 2] == MUX_PWM) |=> pin_oe); // R9

    AST_MUX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PIN && reg_wdata[MUX_LSB +: 2] != MUX_PWM) |=> !pin_oe); // R9

endmodule

// File: tb/test_bl_pwm_top.sv
module test_bl_pwm_top;

    localparam logic [7:0] BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       pwm_o, pin_oe, pin_out;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    bl_pwm_top i_bl_pwm_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_o(pwm_o),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = BASE + off;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [7:0] d);
        @(negedge clk);
        reg_addr = BASE + off;
        #1;
        d = reg_rdata;
    endtask

    // Driver: program a setting from a disabled state and push the expected runs
    task automatic drive(input int p, input int s, input int l, input bit inv, input string tag);
        exp_t e;
        int lc;
        wr(8'd5, 8'h00);
        wr(8'd0, 8'(p));
        wr(8'd1, 8'(s)); wr(8'd2, 8'(s >> 8));
        wr(8'd3, 8'(l)); wr(8'd4, 8'(l >> 8));
        lc = (l < s) ? l : s;
        e.hi = p * lc;
        e.lo = p * (s - lc) + 1;
        e.tag = tag;
        sb_q.push_back(e);
        wr(8'd5, {6'b0, 1'b1, inv});
    endtask

    // Monitor: measure one active run and the following inactive run, compare with queue head
    task automatic monitor(input bit inv);
        exp_t e;
        int hi, lo, guard;
        logic prev, cur;
        prev = pwm_o ^ inv;
        guard = 0;
        forever begin
            @(negedge clk);
            cur = pwm_o ^ inv;
            guard++;
            if ((!prev && cur) || guard > 5000) break;
            prev = cur;
        end
        hi = 1;
        forever begin
            @(negedge clk);
            if ((pwm_o ^ inv) && hi < 5000) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (!(pwm_o ^ inv) && lo < 5000) lo++; else break;
        end
        e = sb_q.pop_front();
        chk({e.tag, " high run"}, hi, e.hi);
        chk({e.tag, " low run"}, lo, e.lo);
    endtask

    task automatic hold_const(input int n, input logic v, input string tag);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o !== v) errs++;
        end
        chk(tag, errs, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R9 pin_oe after reset", int'(pin_oe), 0);
        chk("R7 pwm_o idle after reset", int'(pwm_o), 0);
        rd(8'd5, d); chk("R5 control reset value", int'(d), 0);

        // Register readback
        wr(8'd0, 8'h5A); rd(8'd0, d); chk("R5 prescaler readback", int'(d), 'h5A);
        wr(8'd1, 8'h34); wr(8'd2, 8'h12);
        rd(8'd1, d); chk("R5 scale low byte", int'(d), 'h34);
        rd(8'd2, d); chk("R5 scale high byte", int'(d), 'h12);
        wr(8'd3, 8'hCD); wr(8'd4, 8'hAB);
        rd(8'd3, d); chk("R5 level low byte", int'(d), 'hCD);
        rd(8'd4, d); chk("R5 level high byte", int'(d), 'hAB);
        wr(8'd5, 8'hFC); rd(8'd5, d); chk("R5 control upper bits zero", int'(d), 'h00);
        rd(8'd9, d); chk("R5 unmapped reads zero", int'(d), 0);

        // Period and duty measurements
        drive(1, 10, 3, 1'b0, "R1 R2 p1 s10 l3"); monitor(1'b0);
        drive(3, 5, 2, 1'b0, "R1 R2 p3 s5 l2");   monitor(1'b0);
        drive(2, 4, 4, 1'b0, "R3 level equals scale"); monitor(1'b0);
        drive(1, 4, 9, 1'b0, "R3 level above scale");  monitor(1'b0);
        drive(4, 7, 1, 1'b1, "R8 inverted p4 s7 l1");  monitor(1'b1);
        drive(1, 300, 120, 1'b0, "R2 16-bit scale");   monitor(1'b0);

        // Zero level
        wr(8'd5, 8'h00); wr(8'd0, 8'd2); wr(8'd1, 8'd6); wr(8'd2, 8'd0);
        wr(8'd3, 8'd0); wr(8'd4, 8'd0); wr(8'd5, 8'h02);
        hold_const(60, 1'b0, "R4 zero level never active");

        // Zero prescaler / zero scale
        wr(8'd3, 8'd3); wr(8'd0, 8'd0);
        hold_const(40, 1'b0, "R6 zero prescaler inactive");
        wr(8'd0, 8'd2); wr(8'd1, 8'd0); wr(8'd5, 8'h03);
        hold_const(40, 1'b1, "R6 zero scale inverted inactive");

        // Disable levels and restart timing
        wr(8'd1, 8'd6); wr(8'd5, 8'h01);
        hold_const(20, 1'b1, "R7 disabled inverted level");
        wr(8'd5, 8'h00);
        hold_const(5, 1'b0, "R7 disabled normal level");
        wr(8'd5, 8'h02);
        chk("R7 still idle one edge after enable write", int'(pwm_o), 0);
        @(negedge clk);
        chk("R7 active two edges after enable write", int'(pwm_o), 1);

        // Pin mux
        chk("R9 pin not driven before mux write", int'(pin_oe), 0);
        wr(8'd6, 8'h80);
        chk("R9 pin driven with code 2'b10", int'(pin_oe), 1);
        begin
            int mism = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (pin_out !== pwm_o) mism++;
            end
            chk("R9 pin follows waveform", mism, 0);
        end
        wr(8'd6, 8'h40);
        chk("R9 pin released with code 2'b01", int'(pin_oe), 0);
        chk("R9 released pin data low", int'(pin_out), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule